// File: doc/BRIEF.md
# Dual-Edge Data-Strobe Link Deserialiser

This block receives a serial link carried on two wires, a data line and a strobe line. For every bit, exactly one of the two lines changes. The block rebuilds a bit clock from the exclusive-OR of the two lines, so the rebuilt clock changes level once per bit. Bits that arrive on a rising level change of that clock are the even positions of a word. They go into one shift register. Bits that arrive on a falling change are the odd positions and go into a second shift register. The two registers run independently.

At the rising edge that starts the next word, the even register still holds the previous word's even bits, half a bit ahead of the odd register. That edge is where the two registers are interleaved into one parallel word. The finished word is held in the link-clock domain. A toggle flag then carries it into the system clock domain, where it appears with a single-cycle valid strobe. The block does no character parsing, parity checking or timeout handling: the output is raw bit groups.

Top module: `dsd_deser_top`

## Requirements
- R1: The rebuilt bit clock is data XOR strobe, so a stream in which every bit flips exactly one of the two lines gives one capture per bit, whether the data line or the strobe line is the one that moves.
- R2: Bits received at even stream positions (first, third, fifth, seventh bit of a word) appear at word_o bits 0, 2, 4, 6.
- R3: Bits received at odd stream positions (second, fourth, sixth, eighth bit of a word) appear at word_o bits 1, 3, 5, 7.
- R4: The first bit of each word lands in word_o bit 0. The bit order is ascending, with the even bit first in each pair.
- R5: A word is handed over only when the first bit of the following word arrives. After the eighth bit of a word, with no further bit, no valid is raised for that word.
- R6: Each completed word gives exactly one word_vld_o pulse, one system clock wide, and word_o changes only in a cycle in which word_vld_o is high.
- R7: An active-low reset clears both shift registers, the pair counter and the word-ready flag. Bits received before a mid-word reset never reach the output, and the first bit after release becomes bit 0 of the next word.
- R8: While reset is held, and directly after release, word_vld_o is 0 and word_o is 0.
- R9: Words sent back to back are all delivered in order, with no loss or duplication, as long as one bit period lasts at least SYNC_STAGES+3 system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock that receives the output words |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| ds_data | input | 1 | Link data line |
| ds_strobe | input | 1 | Link strobe line |
| word_o | output | WORD_W | Last delivered parallel word, bit 0 received first |
| word_vld_o | output | 1 | One-cycle pulse marking a new word_o |

## Verification
The hardest case to reach from the ports is a word that is complete in the shift registers but not yet handed over, because no following edge has arrived. The stimulus creates it by stopping the stream right after a word's eighth bit. It then checks that exactly one word is still outstanding, and that a single pad bit releases it. A reset dropped part-way through a word comes next, with the lines returned to idle while reset is held, followed by fresh words that must start at bit 0. Random words mixed with all-zero and all-one words make both the data line and the strobe line carry long runs of transitions.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_sel_e;

   function automatic int unsigned pairs_of(input int unsigned word_w);
      return word_w / 2;
   endfunction

   function automatic int unsigned cnt_width(input int unsigned pairs);
      return (pairs <= 2) ? 1 : $clog2(pairs);
   endfunction

endpackage

// File: rtl/dsd_lane_sr.sv
module dsd_lane_sr
   import dsd_pkg::*;
#(
   parameter int unsigned LANE_W = 4,
   parameter edge_sel_e   EDGE   = EDGE_RISE
) (
   input  logic              bclk,
   input  logic              rst_n,
   input  logic              din,
   output logic [LANE_W-1:0] lane_q
);

   generate
      if (LANE_W < 2) begin : g_bad_width
         $error("dsd_lane_sr: LANE_W must be at least 2");
      end

      if (EDGE == EDGE_FALL) begin : g_fall
         always_ff @(negedge bclk or negedge rst_n) begin
            if (!rst_n) begin
               lane_q <= '0;
            end else begin
               lane_q <= {din, lane_q[LANE_W-1:1]};
            end
         end
      end else begin : g_rise
         always_ff @(posedge bclk or negedge rst_n) begin
            if (!rst_n) begin
               lane_q <= '0;
            end else begin
               lane_q <= {din, lane_q[LANE_W-1:1]};
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dsd_merge.sv
module dsd_merge
   import dsd_pkg::*;
#(
   parameter int unsigned WORD_W = 8,
   localparam int unsigned PAIRS = pairs_of(WORD_W),
   localparam int unsigned CNT_W = cnt_width(PAIRS)
) (
   input  logic              bclk,
   input  logic              rst_n,
   input  logic [PAIRS-1:0]  even_q,
   input  logic [PAIRS-1:0]  odd_q,
   output logic [WORD_W-1:0] hold_q,
   output logic              tog_q,
   output logic [CNT_W-1:0]  pair_cnt_q,
   output logic              have_q
);

   localparam logic [CNT_W-1:0] LAST_PAIR = CNT_W'(PAIRS - 1);

   logic [WORD_W-1:0] merged;

   generate
      for (genvar gi = 0; gi < PAIRS; gi++) begin : g_ilv
         assign merged[2*gi]   = even_q[gi];
         assign merged[2*gi+1] = odd_q[gi];
      end
   endgenerate

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         pair_cnt_q <= '0;
         have_q     <= 1'b0;
         hold_q     <= '0;
         tog_q      <= 1'b0;
      end else begin
         if (pair_cnt_q == LAST_PAIR) begin
            pair_cnt_q <= '0;
            have_q     <= 1'b1;
         end else begin
            pair_cnt_q <= pair_cnt_q + 1'b1;
         end
         if ((pair_cnt_q == '0) && have_q) begin
            hold_q <= merged;
            tog_q  <= ~tog_q;
         end
      end
   end

endmodule

// File: rtl/dsd_tog_sync.sv
module dsd_tog_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tog_in,
   output logic pulse
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_depth
         $error("dsd_tog_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], tog_in};
         last_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign pulse = sync_q[SYNC_STAGES-1] ^ last_q;

endmodule

// File: rtl/dsd_deser_top.sv
module dsd_deser_top
   import dsd_pkg::*;
#(
   parameter int unsigned WORD_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_sys,
   input  logic              rst_n,
   input  logic              ds_data,
   input  logic              ds_strobe,
   output logic [WORD_W-1:0] word_o,
   output logic              word_vld_o
);

   localparam int unsigned PAIRS = pairs_of(WORD_W);
   localparam int unsigned CNT_W = cnt_width(PAIRS);

   generate
      if ((WORD_W % 2) != 0 || WORD_W < 4) begin : g_bad_word
         $error("dsd_deser_top: WORD_W must be even and at least 4");
      end
   endgenerate

   logic              bclk;
   logic [PAIRS-1:0]  even_q;
   logic [PAIRS-1:0]  odd_q;
   logic [WORD_W-1:0] hold_q;
   logic              tog_q;
   logic [CNT_W-1:0]  pair_cnt_q;
   logic              have_q;
   logic              xfer_pulse;

   assign bclk = ds_data ^ ds_strobe;

   dsd_lane_sr #(.LANE_W(PAIRS), .EDGE(EDGE_RISE)) even_lane_i (
      .bclk   (bclk),
      .rst_n  (rst_n),
      .din    (ds_data),
      .lane_q (even_q)
   );

   dsd_lane_sr #(.LANE_W(PAIRS), .EDGE(EDGE_FALL)) odd_lane_i (
      .bclk   (bclk),
      .rst_n  (rst_n),
      .din    (ds_data),
      .lane_q (odd_q)
   );

   dsd_merge #(.WORD_W(WORD_W)) merge_i (
      .bclk       (bclk),
      .rst_n      (rst_n),
      .even_q     (even_q),
      .odd_q      (odd_q),
      .hold_q     (hold_q),
      .tog_q      (tog_q),
      .pair_cnt_q (pair_cnt_q),
      .have_q     (have_q)
   );

   dsd_tog_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
      .clk    (clk_sys),
      .rst_n  (rst_n),
      .tog_in (tog_q),
      .pulse  (xfer_pulse)
   );

   always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) begin
         word_o     <= '0;
         word_vld_o <= 1'b0;
      end else begin
         word_vld_o <= xfer_pulse;
         if (xfer_pulse) begin
            word_o <= hold_q;
         end
      end
   end

endmodule

// File: rtl/dsd_deser_chk.sv
module dsd_deser_chk #(
   parameter int unsigned WORD_W = 8,
   parameter int unsigned CNT_W  = 2
) (
   input logic              clk_sys,
   input logic              bclk,
   input logic              rst_n,
   input logic [WORD_W-1:0] word_o,
   input logic              word_vld_o,
   input logic [CNT_W-1:0]  pair_cnt_q,
   input logic              tog_q,
   input logic              have_q
);

   AST_VLD_ONE_CYCLE: assert property (@(posedge clk_sys) disable iff (!rst_n)
      word_vld_o |=> !word_vld_o); // R6

   AST_WORD_HELD: assert property (@(posedge clk_sys) disable iff (!rst_n)
      !word_vld_o |-> $stable(word_o)); // R6

   AST_RESET_QUIET: assert property (@(posedge clk_sys)
      !rst_n |-> (!word_vld_o && word_o == '0 && pair_cnt_q == '0 && !have_q)); // R8

   AST_TOG_AT_WORD_START: assert property (@(posedge bclk) disable iff (!rst_n)
      (pair_cnt_q != '0) |=> $stable(tog_q)); // R5

   AST_NO_HANDOVER_BEFORE_FULL: assert property (@(posedge bclk) disable iff (!rst_n)
      !have_q |=> $stable(tog_q)); // R7

endmodule

bind dsd_deser_top dsd_deser_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) chk_i (
   .clk_sys    (clk_sys),
   .bclk       (bclk),
   .rst_n      (rst_n),
   .word_o     (word_o),
   .word_vld_o (word_vld_o),
   .pair_cnt_q (pair_cnt_q),
   .tog_q      (tog_q),
   .have_q     (have_q)
);

// File: tb/dsd_deser_top_tb_top.sv
`timescale 1ns/1ps
module dsd_deser_top_tb_top;

   localparam int WORD_W  = 8;
   localparam int BIT_CYC = 8;

   logic              clk_sys = 1'b0;
   logic              rst_n   = 1'b1;
   logic              ds_data = 1'b0;
   logic              ds_strobe = 1'b0;
   logic [WORD_W-1:0] word_o;
   logic              word_vld_o;

   int checks = 0;
   int failures = 0;
   logic [WORD_W-1:0] exp_q [$];
   logic [WORD_W-1:0] got_q [$];
   logic              prev_vld = 1'b0;
   logic [WORD_W-1:0] prev_word = '0;

   always #5 clk_sys = ~clk_sys;

   dsd_deser_top #(.WORD_W(WORD_W), .SYNC_STAGES(2)) dut_i (
      .clk_sys    (clk_sys),
      .rst_n      (rst_n),
      .ds_data    (ds_data),
      .ds_strobe  (ds_strobe),
      .word_o     (word_o),
      .word_vld_o (word_vld_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // model per R2/R3/R4: stream bit k lands at word bit k, even and odd lanes interleaved
   function automatic logic [WORD_W-1:0] model_word(input logic [WORD_W-1:0] bits);
      logic [WORD_W-1:0] w;
      w = '0;
      for (int p = 0; p < WORD_W/2; p++) begin
         w[2*p]   = bits[2*p];
         w[2*p+1] = bits[2*p+1];
      end
      return w;
   endfunction

   always @(negedge clk_sys) begin
      if (rst_n) begin
         if (word_vld_o) begin
            got_q.push_back(word_o);
            if (prev_vld) chk(1'b0, "R6 pulse width", 2, 1);
         end else if (word_o !== prev_word) begin
            chk(1'b0, "R6 word changed without valid", word_o, prev_word);
         end
      end
      prev_vld  = word_vld_o;
      prev_word = word_o;
   end

   // R1: exactly one line toggles per bit
   task automatic send_bit(input logic b);
      @(posedge clk_sys);
      #1;
      if (b == ds_data) ds_strobe = ~ds_strobe;
      else              ds_data   = b;
      repeat (BIT_CYC - 1) @(posedge clk_sys);
   endtask

   task automatic send_word(input logic [WORD_W-1:0] w);
      for (int i = 0; i < WORD_W; i++) send_bit(w[i]);
      exp_q.push_back(model_word(w));
   endtask

   task automatic do_reset();
      @(posedge clk_sys);
      #1;
      rst_n = 1'b0;
      #3;
      ds_data = 1'b0;
      ds_strobe = 1'b0;
      repeat (4) @(posedge clk_sys);
      #1;
      rst_n = 1'b1;
      exp_q.delete();
      got_q.delete();
      repeat (2) @(posedge clk_sys);
   endtask

   task automatic compare_all(input string req);
      chk(got_q.size() == exp_q.size(), {req, " word count"}, got_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
         chk(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
   endtask

   initial begin
      repeat (200000) @(posedge clk_sys);
      failures++;
      checks++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      #1 rst_n = 1'b0;
      repeat (3) @(posedge clk_sys);
      @(negedge clk_sys);
      chk(word_vld_o == 1'b0 && word_o == '0, "R8 in reset", {word_vld_o, word_o}, 0);
      #1 rst_n = 1'b1;
      repeat (2) @(negedge clk_sys);
      chk(word_vld_o == 1'b0 && word_o == '0, "R8 after release", {word_vld_o, word_o}, 0);

      // R2, R3, R4, R5: directed words, last one withheld until a pad bit
      send_word(8'h55);
      send_word(8'hAA);
      send_word(8'h01);
      repeat (30) @(posedge clk_sys);
      chk(got_q.size() == 2, "R5 last word held back", got_q.size(), 2);
      send_bit(1'b1);
      repeat (30) @(posedge clk_sys);
      chk(got_q.size() == 3, "R5 pad bit releases word", got_q.size(), 3);
      if (got_q.size() == 3) begin
         chk(got_q[0] == 8'h55, "R2 even positions", got_q[0], 8'h55);
         chk(got_q[1] == 8'hAA, "R3 odd positions", got_q[1], 8'hAA);
         chk(got_q[2] == 8'h01, "R4 first bit at bit 0", got_q[2], 8'h01);
      end

      // R1: long runs moving only the strobe line, then alternating data
      do_reset();
      send_word(8'h00);
      send_word(8'hFF);
      send_word(8'h80);
      send_word(8'h3C);
      send_bit(1'b0);
      repeat (30) @(posedge clk_sys);
      compare_all("R1 strobe and data transitions");

      // R7: reset part way through a word
      do_reset();
      send_bit(1'b1);
      send_bit(1'b1);
      send_bit(1'b0);
      do_reset();
      chk(word_vld_o == 1'b0 && word_o == '0, "R7 partial word discarded", {word_vld_o, word_o}, 0);
      send_word(8'hC3);
      send_word(8'h5A);
      send_bit(1'b1);
      repeat (30) @(posedge clk_sys);
      compare_all("R7 realigned after reset");

      // R9: random back-to-back words
      do_reset();
      for (int n = 0; n < 24; n++) send_word(WORD_W'($urandom));
      send_bit(1'b0);
      repeat (30) @(posedge clk_sys);
      compare_all("R9 random stream");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule